// File: doc/BRIEF.md
# SIMD Integer Divider with Partitioned Lanes

This block divides one 32-bit operand word by another and returns both quotient and remainder. The word is split into lanes under a width selector: four independent 8-bit lanes, two 16-bit lanes, or one 32-bit lane. Each lane divides on its own, with nothing passing between neighbours. A per-operation flag picks two's-complement or plain binary interpretation. Inside, a restoring algorithm retires two quotient bits per clock, using two chained one-bit stages.

A caller raises `start` while `busy` is low. The operands, width, signedness and latency choice are all sampled on that edge. This is the only back-pressure rule: while `busy` is high, `start` is ignored and the operand pins may change freely. Results come with a one-cycle `done` pulse and stay on the outputs until the next operation finishes. There is no output back-pressure, so the caller must take the result at `done` or later.

Two latency settings are offered. The fixed setting always runs the full 32-bit iteration count, so that vector lanes stay in lockstep. The variable setting stops once the selected lane width is exhausted, which suits a scalar pipeline that wants short divides back early.

Top module: `sdiv_simd`

## Requirements
- R1: `mode` selects the lanes. 0 gives four 8-bit lanes, lane i at bits 8i+7..8i. 1 gives two 16-bit lanes, lane i at bits 16i+15..16i. 2 and 3 both give one 32-bit lane. The result of each lane depends only on that lane's operand bits.
- R2: With `is_signed`=0 and a nonzero divisor lane, the quotient lane is floor(a/b) and the remainder lane is a mod b, both read as unsigned.
- R3: With `is_signed`=1, the operands are two's complement. The quotient is truncated toward zero, and the remainder is zero or has the sign of the dividend.
- R4: A divisor lane of zero gives a quotient lane of all ones and a remainder lane equal to the dividend lane, in both signed and unsigned modes.
- R5: In signed mode, the most negative lane value divided by -1 gives the most negative value as quotient and zero as remainder.
- R6: With `fixed_lat`=1, `done` is high in the cycle after the 18th rising edge that follows the accepting edge, whatever the width.
- R7: With `fixed_lat`=0, that edge count is 6 for 8-bit lanes, 10 for 16-bit lanes and 18 for 32-bit lanes.
- R8: `start` is accepted only while `busy` is low, and `busy` is high from the edge after acceptance. A `start` raised while `busy` is high launches nothing, and its operands never reach the result.
- R9: `done` is high for exactly one cycle, with `busy` still high in that cycle. `quotient` and `remainder` change only at the edge that raises `done`, and they hold afterwards.
- R10: After reset, `busy`, `done`, `quotient` and `remainder` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a division |
| mode | input | 2 | Lane width select (0: 8-bit, 1: 16-bit, 2/3: 32-bit) |
| is_signed | input | 1 | 1: two's-complement operands |
| fixed_lat | input | 1 | 1: always the full 32-bit latency |
| dividend | input | 32 | Packed dividend lanes |
| divisor | input | 32 | Packed divisor lanes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Packed quotient lanes |
| remainder | output | 32 | Packed remainder lanes |

## Verification
A broken lane boundary in the shifter or subtractor shows up as one lane's result depending on another lane's operands. The sweeps expose it on the first operation whose neighbouring lane has a top bit set, which is one `done` pulse after the fault. A wrong iteration count or a faulty state sequence moves `done` away from the edge count in R6 or R7, which is visible on every single operation. A lost sign-correction flag flips the sign of a quotient or remainder on the first signed operation whose operand signs differ. The full 8-bit sweep and the randomized wider runs each reach such an operation within a few dozen operations.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  // Lane width selector as stored after capture (encoding 3 folds onto 32-bit)
  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2
  } lane_w_e;

  // Control states; each step of the main path toggles a single bit
  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_PRE  = 3'b001,
    ST_ITER = 3'b011,
    ST_POST = 3'b010,
    ST_DONE = 3'b110
  } st_e;

  // Number of segments making up one lane
  function automatic int lane_span(lane_w_e m, int nseg);
    int s;
    s = 1 << int'(m);
    return (s > nseg) ? nseg : s;
  endfunction

  // Lowest segment index of the lane holding segment s
  function automatic int lane_lo(int s, int span);
    return s - (s % span);
  endfunction

  // Highest segment index of the lane holding segment s
  function automatic int lane_hi(int s, int span);
    return s - (s % span) + span - 1;
  endfunction

endpackage

// File: rtl/sdiv_seg_sub.sv
// Segmented subtractor: a - b with the borrow chain cut at lane boundaries.
module sdiv_seg_sub
  import sdiv_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int NSEG  = 4
) (
  input  lane_w_e                   mode,
  input  logic [SEG_W*NSEG-1:0]     a,
  input  logic [SEG_W*NSEG-1:0]     b,
  output logic [SEG_W*NSEG-1:0]     diff,
  output logic [NSEG-1:0]           no_borrow
);
  always_comb begin
    int span;
    logic c;
    logic [SEG_W:0] t;
    span = lane_span(mode, NSEG);
    c = 1'b1;
    diff = '0;
    no_borrow = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (lane_lo(s, span) == s) c = 1'b1;
      t = {1'b0, a[s*SEG_W +: SEG_W]} + {1'b0, ~b[s*SEG_W +: SEG_W]} + (SEG_W+1)'(c);
      diff[s*SEG_W +: SEG_W] = t[SEG_W-1:0];
      c = t[SEG_W];
      no_borrow[s] = c;
    end
  end
endmodule

// File: rtl/sdiv_seg_neg.sv
// Segmented two's-complement negation, carries confined to each lane.
module sdiv_seg_neg
  import sdiv_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int NSEG  = 4
) (
  input  lane_w_e               mode,
  input  logic [SEG_W*NSEG-1:0] x,
  output logic [SEG_W*NSEG-1:0] y
);
  always_comb begin
    int span;
    logic c;
    logic [SEG_W:0] t;
    span = lane_span(mode, NSEG);
    c = 1'b1;
    y = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (lane_lo(s, span) == s) c = 1'b1;
      t = {1'b0, ~x[s*SEG_W +: SEG_W]} + (SEG_W+1)'(c);
      y[s*SEG_W +: SEG_W] = t[SEG_W-1:0];
      c = t[SEG_W];
    end
  end
endmodule

// File: rtl/sdiv_r2_step.sv
// One restoring step per lane: shift {rem,quo} left by one, trial-subtract, keep or restore.
module sdiv_r2_step
  import sdiv_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int NSEG  = 4
) (
  input  lane_w_e               mode,
  input  logic [SEG_W*NSEG-1:0] rem_i,
  input  logic [SEG_W*NSEG-1:0] quo_i,
  input  logic [SEG_W*NSEG-1:0] dvs_i,
  output logic [SEG_W*NSEG-1:0] rem_o,
  output logic [SEG_W*NSEG-1:0] quo_o
);
  localparam int DATA_W = SEG_W * NSEG;

  logic [DATA_W-1:0] sh_rem, sh_quo, trial;
  logic [NSEG-1:0]   ovf, nb;

  always_comb begin
    int span, lo, hi, pv;
    span = lane_span(mode, NSEG);
    sh_rem = '0;
    sh_quo = '0;
    ovf    = '0;
    for (int s = 0; s < NSEG; s++) begin
      lo = lane_lo(s, span);
      hi = lane_hi(s, span);
      pv = (s == 0) ? 0 : s - 1;
      sh_rem[s*SEG_W +: SEG_W] = {rem_i[s*SEG_W +: SEG_W-1],
                                  (s == lo) ? quo_i[hi*SEG_W + SEG_W-1]
                                            : rem_i[pv*SEG_W + SEG_W-1]};
      sh_quo[s*SEG_W +: SEG_W] = {quo_i[s*SEG_W +: SEG_W-1],
                                  (s == lo) ? 1'b0 : quo_i[pv*SEG_W + SEG_W-1]};
      ovf[s] = rem_i[hi*SEG_W + SEG_W-1];
    end
  end

  sdiv_seg_sub #(.SEG_W(SEG_W), .NSEG(NSEG)) u_trial (
    .mode      (mode),
    .a         (sh_rem),
    .b         (dvs_i),
    .diff      (trial),
    .no_borrow (nb)
  );

  always_comb begin
    int span, lo, hi;
    logic ge;
    span = lane_span(mode, NSEG);
    rem_o = '0;
    quo_o = '0;
    for (int s = 0; s < NSEG; s++) begin
      lo = lane_lo(s, span);
      hi = lane_hi(s, span);
      ge = ovf[s] | nb[hi];
      rem_o[s*SEG_W +: SEG_W] = ge ? trial[s*SEG_W +: SEG_W] : sh_rem[s*SEG_W +: SEG_W];
      quo_o[s*SEG_W +: SEG_W] = sh_quo[s*SEG_W +: SEG_W] |
                                {{(SEG_W-1){1'b0}}, (ge && s == lo)};
    end
  end
endmodule

// File: rtl/sdiv_ctrl.sv
// Sequencer: idle -> prepare -> iterate -> correct -> done.
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] steps,
  input  logic [CNT_W-1:0] total,
  output st_e              state,
  output logic             step_en,
  output logic             accept
);
  logic [CNT_W-1:0] cnt;

  assign accept  = (state == ST_IDLE) && start;
  assign step_en = (state == ST_ITER) && (cnt < steps);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_PRE;
        ST_PRE: begin
          state <= ST_ITER;
          cnt   <= '0;
        end
        ST_ITER: begin
          if (cnt == total - CNT_W'(1)) state <= ST_POST;
          else cnt <= cnt + CNT_W'(1);
        end
        ST_POST: state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdiv_simd.sv
module sdiv_simd
  import sdiv_pkg::*;
#(
  parameter int SEG_W         = 8,
  parameter int NSEG          = 4,
  parameter int BITS_PER_ITER = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            mode,
  input  logic                  is_signed,
  input  logic                  fixed_lat,
  input  logic [SEG_W*NSEG-1:0] dividend,
  input  logic [SEG_W*NSEG-1:0] divisor,
  output logic                  busy,
  output logic                  done,
  output logic [SEG_W*NSEG-1:0] quotient,
  output logic [SEG_W*NSEG-1:0] remainder
);
  localparam int DATA_W     = SEG_W * NSEG;
  localparam int FULL_ITERS = DATA_W / BITS_PER_ITER;
  localparam int CNT_W      = $clog2(FULL_ITERS) + 1;

  st_e               state;
  logic              step_en, accept;
  logic [CNT_W-1:0]  steps, total;

  lane_w_e           mode_q;
  logic              sgn_q, fix_q;
  logic [DATA_W-1:0] opa_q, opb_q, rem_q, quo_q, dvs_q;
  logic [NSEG-1:0]   negq_q, negr_q, zero_q;
  logic [DATA_W-1:0] quotient_q, remainder_q;

  logic [DATA_W-1:0] neg_in_a, neg_in_b, neg_a, neg_b;
  logic [DATA_W-1:0] abs_a, abs_b, q_fin, r_fin;
  logic [NSEG-1:0]   sa_seg, sb_seg, lz_seg;

  logic [DATA_W-1:0] rem_ch [BITS_PER_ITER+1];
  logic [DATA_W-1:0] quo_ch [BITS_PER_ITER+1];

  // Iteration budget for the captured width
  always_comb begin
    steps = CNT_W'((SEG_W * lane_span(mode_q, NSEG)) / BITS_PER_ITER);
    total = fix_q ? CNT_W'(FULL_ITERS) : steps;
  end

  sdiv_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .steps   (steps),
    .total   (total),
    .state   (state),
    .step_en (step_en),
    .accept  (accept)
  );

  // Shared negators: operands during prepare, results during correction
  assign neg_in_a = (state == ST_POST) ? quo_q : opa_q;
  assign neg_in_b = (state == ST_POST) ? rem_q : opb_q;

  sdiv_seg_neg #(.SEG_W(SEG_W), .NSEG(NSEG)) u_neg_a (
    .mode (mode_q), .x (neg_in_a), .y (neg_a)
  );
  sdiv_seg_neg #(.SEG_W(SEG_W), .NSEG(NSEG)) u_neg_b (
    .mode (mode_q), .x (neg_in_b), .y (neg_b)
  );

  // Per-segment sign, zero detect, magnitude and final correction
  always_comb begin
    int span, lo, hi;
    logic any_nz;
    span  = lane_span(mode_q, NSEG);
    abs_a = '0;
    abs_b = '0;
    q_fin = '0;
    r_fin = '0;
    for (int s = 0; s < NSEG; s++) begin
      lo = lane_lo(s, span);
      hi = lane_hi(s, span);
      sa_seg[s] = sgn_q & opa_q[hi*SEG_W + SEG_W-1];
      sb_seg[s] = sgn_q & opb_q[hi*SEG_W + SEG_W-1];
      any_nz = 1'b0;
      for (int k = 0; k < NSEG; k++) begin
        if (k >= lo && k <= hi) any_nz = any_nz | (|opb_q[k*SEG_W +: SEG_W]);
      end
      lz_seg[s] = ~any_nz;
      abs_a[s*SEG_W +: SEG_W] = sa_seg[s] ? neg_a[s*SEG_W +: SEG_W] : opa_q[s*SEG_W +: SEG_W];
      abs_b[s*SEG_W +: SEG_W] = sb_seg[s] ? neg_b[s*SEG_W +: SEG_W] : opb_q[s*SEG_W +: SEG_W];
      q_fin[s*SEG_W +: SEG_W] = zero_q[s] ? {SEG_W{1'b1}} :
                                negq_q[s] ? neg_a[s*SEG_W +: SEG_W] : quo_q[s*SEG_W +: SEG_W];
      r_fin[s*SEG_W +: SEG_W] = zero_q[s] ? opa_q[s*SEG_W +: SEG_W] :
                                negr_q[s] ? neg_b[s*SEG_W +: SEG_W] : rem_q[s*SEG_W +: SEG_W];
    end
  end

  // Chained single-bit stages forming one multi-bit iteration
  assign rem_ch[0] = rem_q;
  assign quo_ch[0] = quo_q;

  generate
    for (genvar g = 0; g < BITS_PER_ITER; g++) begin : g_stage
      sdiv_r2_step #(.SEG_W(SEG_W), .NSEG(NSEG)) u_step (
        .mode  (mode_q),
        .rem_i (rem_ch[g]),
        .quo_i (quo_ch[g]),
        .dvs_i (dvs_q),
        .rem_o (rem_ch[g+1]),
        .quo_o (quo_ch[g+1])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= LW_8;
      sgn_q       <= 1'b0;
      fix_q       <= 1'b0;
      opa_q       <= '0;
      opb_q       <= '0;
      rem_q       <= '0;
      quo_q       <= '0;
      dvs_q       <= '0;
      negq_q      <= '0;
      negr_q      <= '0;
      zero_q      <= '0;
      quotient_q  <= '0;
      remainder_q <= '0;
    end else begin
      if (accept) begin
        mode_q <= (mode == 2'b11) ? LW_32 : lane_w_e'(mode);
        sgn_q  <= is_signed;
        fix_q  <= fixed_lat;
        opa_q  <= dividend;
        opb_q  <= divisor;
      end
      case (state)
        ST_PRE: begin
          quo_q  <= abs_a;
          dvs_q  <= abs_b;
          rem_q  <= '0;
          negq_q <= sa_seg ^ sb_seg;
          negr_q <= sa_seg;
          zero_q <= lz_seg;
        end
        ST_ITER: begin
          if (step_en) begin
            rem_q <= rem_ch[BITS_PER_ITER];
            quo_q <= quo_ch[BITS_PER_ITER];
          end
        end
        ST_POST: begin
          quotient_q  <= q_fin;
          remainder_q <= r_fin;
        end
        default: ;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign quotient  = quotient_q;
  assign remainder = remainder_q;

endmodule

// File: rtl/sdiv_simd_chk.sv
module sdiv_simd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [1:0]  mode,
  input logic        is_signed,
  input logic        fixed_lat,
  input logic [31:0] dividend,
  input logic [31:0] divisor,
  input logic        busy,
  input logic        done,
  input logic [31:0] quotient,
  input logic [31:0] remainder
);
  logic [5:0]  lat_cnt;
  logic [5:0]  exp_iters;
  logic        cap_fix, cap_sgn, cap_w32;
  logic [31:0] cap_a, cap_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt   <= '0;
      exp_iters <= '0;
      cap_fix   <= 1'b0;
      cap_sgn   <= 1'b0;
      cap_w32   <= 1'b0;
      cap_a     <= '0;
      cap_b     <= '0;
    end else if (!busy && start) begin
      lat_cnt   <= 6'd1;
      exp_iters <= (mode == 2'd0) ? 6'd4 : (mode == 2'd1) ? 6'd8 : 6'd16;
      cap_fix   <= fixed_lat;
      cap_sgn   <= is_signed;
      cap_w32   <= mode[1];
      cap_a     <= dividend;
      cap_b     <= divisor;
    end else if (busy) begin
      lat_cnt <= lat_cnt + 6'd1;
    end
  end

  // R6
  p_fixed_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_fix) |-> (lat_cnt == 6'd19));

  // R7
  p_var_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cap_fix) |-> (lat_cnt == exp_iters + 6'd3));

  // R8
  p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R9
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (done || ($stable(quotient) && $stable(remainder))));

  // R4
  p_div_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_w32 && cap_b == 32'd0) |-> (quotient == 32'hFFFF_FFFF && remainder == cap_a));

  // R5
  p_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_w32 && cap_sgn && cap_a == 32'h8000_0000 && cap_b == 32'hFFFF_FFFF)
      |-> (quotient == 32'h8000_0000 && remainder == 32'd0));

endmodule

bind sdiv_simd sdiv_simd_chk chk_i (.*);

// File: tb/sdiv_simd_tb_top.sv
module sdiv_simd_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  mode;
  logic        is_signed;
  logic        fixed_lat;
  logic [31:0] dividend, divisor;
  logic        busy, done;
  logic [31:0] quotient, remainder;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdiv_simd dut_i (
    .clk (clk), .rst_n (rst_n), .start (start), .mode (mode),
    .is_signed (is_signed), .fixed_lat (fixed_lat),
    .dividend (dividend), .divisor (divisor),
    .busy (busy), .done (done), .quotient (quotient), .remainder (remainder)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // Arithmetic reference per lane
  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic [1:0] m, input bit sg,
                                output logic [31:0] q, output logic [31:0] r,
                                output string tag);
    int span, w, nl;
    longint mask, av, bv, sav, sbv, qv, rv;
    bit zf, of;
    span = (m >= 2) ? 4 : (1 << m);
    w    = 8 * span;
    nl   = 4 / span;
    mask = (longint'(1) << w) - 1;
    q = '0; r = '0; zf = 0; of = 0;
    for (int l = 0; l < nl; l++) begin
      av = (longint'(a) >> (l*w)) & mask;
      bv = (longint'(b) >> (l*w)) & mask;
      sav = (av >= (longint'(1) << (w-1))) ? av - (longint'(1) << w) : av;
      sbv = (bv >= (longint'(1) << (w-1))) ? bv - (longint'(1) << w) : bv;
      if (bv == 0) begin
        qv = mask; rv = av; zf = 1;
      end else if (sg) begin
        qv = sav / sbv; rv = sav % sbv;
        if (sav == -(longint'(1) << (w-1)) && sbv == -1) of = 1;
      end else begin
        qv = av / bv; rv = av % bv;
      end
      q = q | (32'(qv & mask) << (l*w));
      r = r | (32'(rv & mask) << (l*w));
    end
    tag = zf ? "R4" : of ? "R5" : (m == 2'd0) ? "R1" : sg ? "R3" : "R2";
  endfunction

  // One operation; optionally pokes start with other operands while busy
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                        input bit sg, input bit fx, input bit poke);
    logic [31:0] eq, er;
    string tag;
    int k, exp_lat;
    model(a, b, m, sg, eq, er, tag);
    exp_lat = fx ? 18 : ((m == 2'd0) ? 6 : (m == 2'd1) ? 10 : 18);
    @(negedge clk);
    dividend = a; divisor = b; mode = m; is_signed = sg; fixed_lat = fx; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    k = 0;
    start = poke;
    if (poke) begin dividend = ~a; divisor = b + 32'd5; end
    check(busy == 1'b1, "R8", "busy after accept", 32'(busy), 32'd1);
    while (!done && k < 60) begin
      @(negedge clk);
      k++;
      if (poke && k == 2) start = 1'b0;
    end
    check(k == exp_lat, fx ? "R6" : "R7", "done latency", 32'(k), 32'(exp_lat));
    check(quotient == eq, tag, "quotient", quotient, eq);
    check(remainder == er, tag, "remainder", remainder, er);
    @(negedge clk);
    check(done == 1'b0, "R9", "done pulse width", 32'(done), 32'd0);
    if (poke) begin
      check(busy == 1'b0, "R8", "start while busy launched an op", 32'(busy), 32'd0);
      repeat (3) @(negedge clk);
      check(quotient == eq, "R9", "quotient held", quotient, eq);
      check(remainder == er, "R9", "remainder held", remainder, er);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 2'd0; is_signed = 1'b0; fixed_lat = 1'b0;
    dividend = '0; divisor = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(busy == 1'b0, "R10", "busy", 32'(busy), 32'd0);
    check(done == 1'b0, "R10", "done", 32'(done), 32'd0);
    check(quotient == 32'd0, "R10", "quotient", quotient, 32'd0);
    check(remainder == 32'd0, "R10", "remainder", remainder, 32'd0);

    // Corner cases: R4 zero divisors, R5 overflow, mode 3, R8 ignored start
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 2'd2, 1, 0, 0);
    run_op(32'h8000_8000, 32'hFFFF_FFFF, 2'd1, 1, 0, 0);
    run_op(32'h8080_8080, 32'hFFFF_FFFF, 2'd0, 1, 1, 0);
    run_op(32'h1234_5678, 32'h0000_0000, 2'd2, 0, 0, 0);
    run_op(32'hF234_5678, 32'h0000_0000, 2'd3, 1, 0, 0);
    run_op(32'h1234_8765, 32'h0000_0003, 2'd1, 1, 0, 0);
    run_op(32'h9ABC_DEF0, 32'h0013_0000, 2'd0, 0, 0, 0);
    run_op(32'hFFFF_FFF9, 32'h0000_0002, 2'd3, 1, 0, 0);
    run_op(32'hDEAD_BEEF, 32'h0000_1234, 2'd2, 0, 0, 1);
    run_op(32'h8765_4321, 32'hFF01_0F02, 2'd0, 1, 1, 1);

    // R1/R2/R3: 8-bit lanes, every dividend against sixteen divisor patterns
    for (int sg = 0; sg < 2; sg++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 16; bi++) begin
          logic [7:0] a0, a1, a2, a3, b0, b1, b2, b3;
          a0 = 8'(a);            b0 = 8'(bi * 17);
          a1 = ~8'(a);           b1 = 8'(bi + 1);
          a2 = 8'(a * 37 + 11);  b2 = 8'(255 - bi * 3);
          a3 = 8'(a) ^ 8'h80;    b3 = (bi == 15) ? 8'hFF : 8'(bi << 4);
          run_op({a3, a2, a1, a0}, {b3, b2, b1, b0}, 2'd0, sg[0], 0, 0);
        end
      end
    end

    // R2/R3: 16-bit and 32-bit lanes, pseudo-random with scaled divisors
    for (int i = 0; i < 1600; i++) begin
      logic [31:0] a, b, sel;
      a   = next_rand();
      sel = next_rand();
      b   = next_rand() >> sel[4:0];
      if (sel[9:7] == 3'd0) b = 32'd0;
      if (sel[12:10] == 3'd1) a = 32'h8000_8000;
      if (sel[15:13] == 3'd2) b = 32'hFFFF_FFFF;
      run_op(a, b, (i % 2 == 0) ? 2'd1 : (sel[20] ? 2'd3 : 2'd2), sel[5], 0, 0);
    end

    // R6: fixed latency across all widths
    for (int i = 0; i < 320; i++) begin
      logic [31:0] a, b;
      a = next_rand();
      b = next_rand() >> (i % 29);
      run_op(a, b, 2'(i % 4), i[2], 1, 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog expired actual=busy%0d expected=finished", busy);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule